// File: doc/BRIEF.md
# Highway and Farm-Road Signal Controller

This block drives the lamps at the crossing of a busy highway and a lightly used farm road. The highway shows green by default. A sensor input reports that a vehicle is waiting on the farm road. When a vehicle is waiting and the highway has had green for at least the long interval, the right of way passes to the farm road, with a yellow phase on the highway first. The farm road keeps green while vehicles remain, but never longer than the long interval. Its own yellow phase then hands the right of way back to the highway.

All four phases are timed by one shared interval timer. The timer restarts on every phase change. It reports two flags: the short interval has expired, and the long interval has expired. Both flags stay set until the next restart. The short interval times the yellow phases and the long interval times the green phases. Both lengths are parameters given in clock cycles.

Top module: `hwy_farm_ctrl`

## Requirements
- R1: While reset (active low) is asserted, and in the first cycle after it is released, the lamps show highway green and farm red. Reset also restarts the interval timer.
- R2: Each road shows exactly one of its green, yellow and red lamps in every cycle.
- R3: With no vehicle reported, the highway green holds indefinitely.
- R4: Highway green ends only when a vehicle is reported and the long interval has expired. After each entry into highway green (including the one after reset), green lasts at least LONG_CYCLES+1 cycles. If a vehicle arrives after the interval has expired, highway yellow appears in the next cycle.
- R5: Highway yellow lasts exactly SHORT_CYCLES+1 cycles and is followed by farm green with highway red.
- R6: If the sensor input is low in a farm-green cycle, the next cycle shows farm yellow.
- R7: With a vehicle reported throughout, farm green lasts exactly LONG_CYCLES+1 cycles.
- R8: Farm yellow lasts exactly SHORT_CYCLES+1 cycles and is followed by highway green with farm red.
- R9: The highway green and the farm green are never on together, and in every cycle at least one road shows red.
- R10: Every phase change restarts the timer, so the short flag is low in the first cycle of each new phase.

Lamp codes used by the checks, written as {highway G,Y,R, farm G,Y,R}:
- highway green = 100_001
- highway yellow = 010_001
- farm green = 001_100
- farm yellow = 001_010

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| car_waiting | input | 1 | High while a vehicle is detected on the farm road |
| hwy_green | output | 1 | Highway green lamp |
| hwy_yellow | output | 1 | Highway yellow lamp |
| hwy_red | output | 1 | Highway red lamp |
| farm_green | output | 1 | Farm-road green lamp |
| farm_yellow | output | 1 | Farm-road yellow lamp |
| farm_red | output | 1 | Farm-road red lamp |

## Verification
The hardest case to reach from the ports is a vehicle that appears and leaves before the long interval has expired. The timer's expiry cannot be seen directly, so the stimulus pulses the sensor for one cycle early in highway green. It then checks that green still holds well past the long interval. The saturated-timer corner is reached by holding the sensor low for twice the long interval and then raising it, which must give yellow on the very next cycle. A reset asserted during farm green checks that both the phase and the timer restart.

// File: rtl/hwy_farm_pkg.sv
package hwy_farm_pkg;

  typedef enum logic [1:0] {
    PH_HWY_GO    = 2'd0,
    PH_HWY_WARN  = 2'd1,
    PH_FARM_GO   = 2'd2,
    PH_FARM_WARN = 2'd3
  } phase_e;

  typedef struct packed {
    logic green;
    logic yellow;
    logic red;
  } lamp_t;

  localparam lamp_t LAMP_GO   = '{green: 1'b1, yellow: 1'b0, red: 1'b0};
  localparam lamp_t LAMP_WARN = '{green: 1'b0, yellow: 1'b1, red: 1'b0};
  localparam lamp_t LAMP_STOP = '{green: 1'b0, yellow: 1'b0, red: 1'b1};

  // Next phase from the current phase, the sensor and the two timer flags.
  function automatic phase_e phase_step(phase_e cur, logic car,
                                        logic short_done, logic long_done);
    phase_e nxt;
    nxt = cur;
    unique case (cur)
      PH_HWY_GO:    if (car && long_done)   nxt = PH_HWY_WARN;
      PH_HWY_WARN:  if (short_done)         nxt = PH_FARM_GO;
      PH_FARM_GO:   if (long_done || !car)  nxt = PH_FARM_WARN;
      PH_FARM_WARN: if (short_done)         nxt = PH_HWY_GO;
      default:                              nxt = PH_HWY_GO;
    endcase
    return nxt;
  endfunction

  function automatic lamp_t hwy_lamp(phase_e p);
    unique case (p)
      PH_HWY_GO:   return LAMP_GO;
      PH_HWY_WARN: return LAMP_WARN;
      default:     return LAMP_STOP;
    endcase
  endfunction

  function automatic lamp_t farm_lamp(phase_e p);
    unique case (p)
      PH_FARM_GO:   return LAMP_GO;
      PH_FARM_WARN: return LAMP_WARN;
      default:      return LAMP_STOP;
    endcase
  endfunction

  // Saturating increment of the timer count.
  function automatic logic [31:0] count_step(logic [31:0] cnt, logic [31:0] limit);
    return (cnt >= limit) ? limit : cnt + 32'd1;
  endfunction

endpackage

// File: rtl/interval_timer.sv
module interval_timer
  import hwy_farm_pkg::*;
#(
  parameter int SHORT_CYCLES = 4,
  parameter int LONG_CYCLES  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic short_done,
  output logic long_done
);

  localparam int CNT_W = $clog2(LONG_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic [31:0]      cnt_next;

  assign cnt_next = count_step(32'(cnt), 32'(LONG_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt_next[CNT_W-1:0];
  end

  assign short_done = (32'(cnt) >= 32'(SHORT_CYCLES));
  assign long_done  = (32'(cnt) >= 32'(LONG_CYCLES));

  // R10: a restart leaves the short flag low in the following cycle
  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> !short_done);

  // The long flag never rises ahead of the short flag (R5, R8 timing order)
  assert_flag_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    long_done |-> short_done);

endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer
  import hwy_farm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   car,
  input  logic   short_done,
  input  logic   long_done,
  output phase_e phase,
  output logic   restart
);

  phase_e phase_nxt;

  assign phase_nxt = phase_step(phase, car, short_done, long_done);
  assign restart   = (phase_nxt != phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_HWY_GO;
    else        phase <= phase_nxt;
  end

  // R4: leaving highway green needs both the sensor and the long flag
  assert_hwy_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HWY_GO && !(car && long_done)) |=> phase == PH_HWY_GO);

  // R5: highway yellow always hands over to farm green
  assert_warn_to_farm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_HWY_WARN && phase != PH_HWY_WARN) |-> phase == PH_FARM_GO);

  // R8: farm yellow always returns to highway green
  assert_warn_to_hwy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_FARM_WARN && phase != PH_FARM_WARN) |-> phase == PH_HWY_GO);

endmodule

// File: rtl/lamp_decoder.sv
module lamp_decoder
  import hwy_farm_pkg::*;
(
  input  phase_e phase,
  output lamp_t  hwy,
  output lamp_t  farm
);

  assign hwy  = hwy_lamp(phase);
  assign farm = farm_lamp(phase);

endmodule

// File: rtl/hwy_farm_ctrl.sv
module hwy_farm_ctrl
  import hwy_farm_pkg::*;
#(
  parameter int SHORT_CYCLES = 4,
  parameter int LONG_CYCLES  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic car_waiting,
  output logic hwy_green,
  output logic hwy_yellow,
  output logic hwy_red,
  output logic farm_green,
  output logic farm_yellow,
  output logic farm_red
);

  phase_e phase;
  logic   restart;
  logic   short_done;
  logic   long_done;
  lamp_t  hwy;
  lamp_t  farm;

  interval_timer #(
    .SHORT_CYCLES(SHORT_CYCLES),
    .LONG_CYCLES (LONG_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .short_done(short_done),
    .long_done (long_done)
  );

  phase_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .car       (car_waiting),
    .short_done(short_done),
    .long_done (long_done),
    .phase     (phase),
    .restart   (restart)
  );

  lamp_decoder u_lamps (
    .phase(phase),
    .hwy  (hwy),
    .farm (farm)
  );

  assign hwy_green   = hwy.green;
  assign hwy_yellow  = hwy.yellow;
  assign hwy_red     = hwy.red;
  assign farm_green  = farm.green;
  assign farm_yellow = farm.yellow;
  assign farm_red    = farm.red;

  // R2: exactly one lamp per road
  assert_one_lamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hwy_green, hwy_yellow, hwy_red}) == 1 &&
    $countones({farm_green, farm_yellow, farm_red}) == 1);

  // R9: the two greens are never on together, and some road shows red
  assert_no_dual_green_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hwy_green && farm_green) && (hwy_red || farm_red));

  // R4: highway green ends only after the long interval with a vehicle waiting
  assert_min_green_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hwy_green) |-> $past(long_done) && $past(car_waiting));

  // R6: an empty farm road in a farm-green cycle gives farm yellow next
  assert_farm_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (farm_green && !car_waiting) |=> farm_yellow);

  // R7: farm green never outlasts the long interval
  assert_farm_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (farm_green && long_done) |=> !farm_green);

endmodule

// File: tb/hwy_farm_ctrl_tb.sv
module hwy_farm_ctrl_tb;

  localparam int SHORT = 3;
  localparam int LONG  = 9;

  localparam logic [5:0] P_HG = 6'b100_001;
  localparam logic [5:0] P_HY = 6'b010_001;
  localparam logic [5:0] P_FG = 6'b001_100;
  localparam logic [5:0] P_FY = 6'b001_010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car = 1'b0;
  logic hg, hy, hr, fg, fy, fr;

  int n_tests = 0;
  int n_fail  = 0;
  int mon_bad = 0;

  always #5 clk = ~clk;

  hwy_farm_ctrl #(.SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)) u_dut (
    .clk(clk), .rst_n(rst_n), .car_waiting(car),
    .hwy_green(hg), .hwy_yellow(hy), .hwy_red(hr),
    .farm_green(fg), .farm_yellow(fy), .farm_red(fr)
  );

  function automatic logic [5:0] lights();
    return {hg, hy, hr, fg, fy, fr};
  endfunction

  // Continuous monitor for R2 and R9
  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones({hg, hy, hr}) != 1 || $countones({fg, fy, fr}) != 1) mon_bad++;
      if ((hg && fg) || !(hr || fr)) mon_bad++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_pat(input string req, input logic [5:0] exp);
    check(lights() == exp, req, int'(lights()), int'(exp));
  endtask

  // Reset with sensor preset; ends on the first negedge after release.
  task automatic do_reset(input logic car_val);
    @(negedge clk);
    rst_n = 1'b0;
    car   = car_val;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Count negedges on which the lamp pattern equals pat.
  task automatic run_phase(input logic [5:0] pat, output int n);
    n = 0;
    while (lights() == pat && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_pat("R1 lamps during reset", P_HG);
    rst_n = 1'b1;
    check_pat("R1 lamps after release", P_HG);
  endtask

  task automatic t_full_cycle();
    int n;
    do_reset(1'b1);
    run_phase(P_HG, n);
    check(n == LONG + 1, "R4 first highway green length", n, LONG + 1);
    check_pat("R4 yellow follows green", P_HY);
    run_phase(P_HY, n);
    check(n == SHORT + 1, "R5 highway yellow length", n, SHORT + 1);
    check_pat("R5 farm green follows", P_FG);
    run_phase(P_FG, n);
    check(n == LONG + 1, "R7 farm green max length", n, LONG + 1);
    check_pat("R7 farm yellow follows", P_FY);
    run_phase(P_FY, n);
    check(n == SHORT + 1, "R8 farm yellow length", n, SHORT + 1);
    check_pat("R8 highway green follows", P_HG);
    run_phase(P_HG, n);
    check(n == LONG + 1, "R10 timer restarted, highway green again", n, LONG + 1);
  endtask

  task automatic t_car_leaves();
    int n;
    do_reset(1'b1);
    run_phase(P_HG, n);
    run_phase(P_HY, n);
    check_pat("R6 in farm green", P_FG);
    car = 1'b0;
    @(negedge clk);
    check_pat("R6 farm yellow after car leaves", P_FY);
    run_phase(P_FY, n);
    check(n == SHORT + 1, "R8 farm yellow length after early end", n, SHORT + 1);
    n = 0;
    for (int i = 0; i < 3 * LONG; i++) begin
      if (lights() == P_HG) n++;
      @(negedge clk);
    end
    check(n == 3 * LONG, "R3 green holds with empty farm road", n, 3 * LONG);
  endtask

  task automatic t_late_car();
    int n;
    do_reset(1'b0);
    n = 0;
    for (int i = 0; i < 2 * LONG; i++) begin
      if (lights() == P_HG) n++;
      @(negedge clk);
    end
    check(n == 2 * LONG, "R3 no vehicle keeps green", n, 2 * LONG);
    car = 1'b1;
    @(negedge clk);
    check_pat("R4 late vehicle gives yellow next cycle", P_HY);
  endtask

  task automatic t_car_blip();
    int n;
    do_reset(1'b0);
    repeat (LONG / 2) @(negedge clk);
    car = 1'b1;
    @(negedge clk);
    car = 1'b0;
    n = 0;
    for (int i = 0; i < 2 * LONG; i++) begin
      if (lights() == P_HG) n++;
      @(negedge clk);
    end
    check(n == 2 * LONG, "R4 early blip does not end green", n, 2 * LONG);
  endtask

  task automatic t_reset_mid_farm();
    int n;
    do_reset(1'b1);
    run_phase(P_HG, n);
    run_phase(P_HY, n);
    repeat (2) @(negedge clk);
    check_pat("R1 setup in farm green", P_FG);
    rst_n = 1'b0;
    @(negedge clk);
    check_pat("R1 reset during farm green", P_HG);
    rst_n = 1'b1;
    run_phase(P_HG, n);
    check(n == LONG + 1, "R1 timer cleared by reset", n, LONG + 1);
  endtask

  initial begin
    t_reset();
    t_full_cycle();
    t_car_leaves();
    t_late_car();
    t_car_blip();
    t_reset_mid_farm();
    check(mon_bad == 0, "R2/R9 lamp consistency violations", mon_bad, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule